// File: doc/BRIEF.md
# Masked Fixed-Priority Interrupt Arbiter

This block sits between a set of interrupting peripherals and a processor that has a single interrupt input. Each peripheral drives its own request line. The arbiter passes a request on only when that channel's mask bit is set and the arbiter's global enable is on. It combines the surviving requests into one interrupt output. When the processor acknowledges, the arbiter picks one channel and returns a one-hot acknowledge to it. It also drives that channel's 8-bit table index, which software uses to find the service routine in a 256-entry jump table.

Software sets the arbiter up through a small memory-mapped register window. The window holds a mask with one bit per channel, one index register per channel and a single enable bit. The channel with the lowest number always wins. The choice is frozen at the first clock edge that sees the acknowledge high, so later requests cannot disturb a handshake that is under way. The number of channels and the base address are parameters. The default is two channels at base 0xFFF0.

Top module: `intarb_top`

## Requirements
- R1: After reset the mask, every index register and the enable read back as 0, and `int_o`, `iack_o` and `vec_oe_o` are 0.
- R2: Writes land at these addresses: the mask at base+0 (bit c enables channel c, and bits above the channel count read as 0), the index of channel c at base+1+c, and the enable at base+1+NUM_CH (bit 0 only, upper bits read as 0). A read returns the stored value in the same cycle.
- R3: `int_o` is 1 in the same cycle in which any request is high with its mask bit set while the enable is 1, and it is 0 otherwise.
- R4: While the enable is 0, requests raise no interrupt, and an acknowledge produces no `iack_o` bit and no index.
- R5: A channel whose mask bit is 0 is never acknowledged, even while its request is high.
- R6: When several enabled requests are pending, the lowest-numbered channel is acknowledged.
- R7: At the first clock edge with `inta_i` high, the winner is latched. From the next cycle `iack_o` is one-hot for that channel, `vec_o` carries its index and `vec_oe_o` is 1. All three hold while `inta_i` stays high, whatever the requests do.
- R8: While `inta_i` is 0, `iack_o` is 0, `vec_oe_o` is 0 and `vec_o` is 0.
- R9: After the acknowledge ends, `int_o` stays 1 if another enabled request is still pending, and the next acknowledge serves that channel.
- R10: A write to an address outside the register window changes no register. A read from outside the window returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 16 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_we_i | input | 1 | Register write strobe |
| bus_rdata_o | output | 8 | Register read data, combinational from the address |
| irq_req_i | input | NUM_CH | Request line from each peripheral |
| int_o | output | 1 | Interrupt to the processor |
| inta_i | input | 1 | Interrupt acknowledge from the processor |
| iack_o | output | NUM_CH | One-hot acknowledge to the winning peripheral |
| vec_o | output | 8 | Table index of the winning channel |
| vec_oe_o | output | 1 | Drive enable for `vec_o` onto the data bus |

## Verification
The assertions take for granted that `inta_i` is low while reset is applied. They also take for granted that every rising and falling edge of the acknowledge spans at least one clock edge. The hold property for R7 depends on this: it compares acknowledge values only across clock edges at which `inta_i` was seen high. The stimulus meets both conditions. It changes every input on the falling clock edge, holds the acknowledge high for at least one full cycle, and never toggles it twice within one clock period. It also keeps the mask and enable unchanged during a handshake, because the property for R6 reads them at the latch edge.

// File: rtl/intarb_pkg.sv
`timescale 1ns/1ps
package intarb_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned BASE_DEFAULT = 'hFFF0;
endpackage

// File: rtl/intarb_regs.sv
`timescale 1ns/1ps
module intarb_regs #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BASE   = 'hFFF0
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic                           we_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic [NUM_CH-1:0]              mask_o,
  output logic                           en_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]  idx_o
);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] ENA_A  = ADDR_W'(BASE + NUM_CH + 1);

  logic [NUM_CH-1:0] mask_q;
  logic              en_q;
  logic [NUM_CH-1:0][DATA_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      en_q   <= 1'b0;
    end else if (we_i) begin
      if (addr_i == MASK_A) mask_q <= wdata_i[NUM_CH-1:0];
      if (addr_i == ENA_A)  en_q   <= wdata_i[0];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_idx
    localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(BASE + c + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      idx_q[c] <= '0;
      else if (we_i && addr_i == IDX_A) idx_q[c] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == MASK_A) rdata_o = DATA_W'(mask_q);
    if (addr_i == ENA_A)  rdata_o = DATA_W'(en_q);
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == ADDR_W'(BASE + c + 1)) rdata_o = idx_q[c];
    end
  end

  assign mask_o = mask_q;
  assign en_o   = en_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/intarb_pick.sv
`timescale 1ns/1ps
module intarb_pick #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic              en_i,
  output logic              any_o,
  output logic [NUM_CH-1:0] win_o
);
  logic [NUM_CH-1:0] eff;
  logic [NUM_CH:0]   seen;

  assign eff     = req_i & mask_i & {NUM_CH{en_i}};
  assign seen[0] = 1'b0;

  // lowest index wins: each channel is blocked by any lower pending one
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chain
    assign win_o[c]    = eff[c] & ~seen[c];
    assign seen[c + 1] = seen[c] | eff[c];
  end

  assign any_o = seen[NUM_CH];
endmodule

// File: rtl/intarb_ack.sv
`timescale 1ns/1ps
module intarb_ack #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          inta_i,
  input  logic [NUM_CH-1:0]             win_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0] idx_i,
  output logic [NUM_CH-1:0]             iack_o,
  output logic [DATA_W-1:0]             vec_o,
  output logic                          vec_oe_o
);
  logic              inta_q;
  logic [NUM_CH-1:0] grant_q;
  logic [DATA_W-1:0] vec_q;
  logic [DATA_W-1:0] vec_d;

  always_comb begin
    vec_d = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (win_i[c]) vec_d = vec_d | idx_i[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inta_q  <= 1'b0;
      grant_q <= '0;
      vec_q   <= '0;
    end else begin
      inta_q <= inta_i;
      if (inta_i && !inta_q) begin
        grant_q <= win_i;
        vec_q   <= vec_d;
      end else if (!inta_i) begin
        grant_q <= '0;
      end
    end
  end

  // outputs gated by the live acknowledge so the bus is released at once
  assign iack_o   = inta_i ? grant_q : '0;
  assign vec_oe_o = inta_i & (|grant_q);
  assign vec_o    = vec_oe_o ? vec_q : '0;
endmodule

// File: rtl/intarb_top.sv
`timescale 1ns/1ps
module intarb_top #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned BASE   = intarb_pkg::BASE_DEFAULT
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [intarb_pkg::ADDR_W-1:0] bus_addr_i,
  input  logic [intarb_pkg::DATA_W-1:0] bus_wdata_i,
  input  logic                          bus_we_i,
  output logic [intarb_pkg::DATA_W-1:0] bus_rdata_o,
  input  logic [NUM_CH-1:0]             irq_req_i,
  output logic                          int_o,
  input  logic                          inta_i,
  output logic [NUM_CH-1:0]             iack_o,
  output logic [intarb_pkg::DATA_W-1:0] vec_o,
  output logic                          vec_oe_o
);
  localparam int unsigned AW = intarb_pkg::ADDR_W;
  localparam int unsigned DW = intarb_pkg::DATA_W;

  logic [NUM_CH-1:0]         mask_w;
  logic                      en_w;
  logic [NUM_CH-1:0][DW-1:0] idx_w;
  logic [NUM_CH-1:0]         win_w;

  intarb_regs #(.NUM_CH(NUM_CH), .ADDR_W(AW), .DATA_W(DW), .BASE(BASE)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .we_i    (bus_we_i),
    .rdata_o (bus_rdata_o),
    .mask_o  (mask_w),
    .en_o    (en_w),
    .idx_o   (idx_w)
  );

  intarb_pick #(.NUM_CH(NUM_CH)) i_pick (
    .req_i  (irq_req_i),
    .mask_i (mask_w),
    .en_i   (en_w),
    .any_o  (int_o),
    .win_o  (win_w)
  );

  intarb_ack #(.NUM_CH(NUM_CH), .DATA_W(DW)) i_ack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inta_i   (inta_i),
    .win_i    (win_w),
    .idx_i    (idx_w),
    .iack_o   (iack_o),
    .vec_o    (vec_o),
    .vec_oe_o (vec_oe_o)
  );
endmodule

// File: rtl/intarb_chk.sv
`timescale 1ns/1ps
module intarb_chk #(
  parameter int unsigned NUM_CH = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] irq_req_i,
  input logic [NUM_CH-1:0] mask_w,
  input logic              en_w,
  input logic              int_o,
  input logic              inta_i,
  input logic [NUM_CH-1:0] iack_o,
  input logic              vec_oe_o
);
  logic [NUM_CH-1:0] eff;
  assign eff = irq_req_i & mask_w & {NUM_CH{en_w}};

  // R8
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inta_i |-> (iack_o == '0 && !vec_oe_o));

  // R7
  onehot_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(iack_o));

  // R7
  ack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && $past(inta_i) && $past(inta_i, 2)) |-> $stable(iack_o));

  // R6
  low_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !$past(inta_i) && eff[0]) |=> (!inta_i || iack_o[0]));

  // R4
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_w |-> !int_o);

  // R9
  still_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(inta_i) && eff != '0) |-> int_o);
endmodule

bind intarb_top intarb_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_req_i (irq_req_i),
  .mask_w    (mask_w),
  .en_w      (en_w),
  .int_o     (int_o),
  .inta_i    (inta_i),
  .iack_o    (iack_o),
  .vec_oe_o  (vec_oe_o)
);

// File: tb/test_intarb_top.sv
`timescale 1ns/1ps
module test_intarb_top;
  localparam logic [15:0] A_MASK = 16'hFFF0;
  localparam logic [15:0] A_IX0  = 16'hFFF1;
  localparam logic [15:0] A_IX1  = 16'hFFF2;
  localparam logic [15:0] A_ENA  = 16'hFFF3;
  localparam logic [7:0]  IX0    = 8'd13;
  localparam logic [7:0]  IX1    = 8'd17;

  // {mask[1:0], en, req[1:0], exp_int, exp_ack[1:0], exp_vec[7:0]}
  localparam logic [15:0] VECS [8] = '{
    {2'b11, 1'b1, 2'b01, 1'b1, 2'b01, IX0},
    {2'b11, 1'b1, 2'b10, 1'b1, 2'b10, IX1},
    {2'b11, 1'b1, 2'b11, 1'b1, 2'b01, IX0},
    {2'b10, 1'b1, 2'b11, 1'b1, 2'b10, IX1},
    {2'b01, 1'b1, 2'b10, 1'b0, 2'b00, 8'd0},
    {2'b11, 1'b0, 2'b11, 1'b0, 2'b00, 8'd0},
    {2'b00, 1'b1, 2'b11, 1'b0, 2'b00, 8'd0},
    {2'b11, 1'b1, 2'b00, 1'b0, 2'b00, 8'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0;
  logic [7:0]  rdata;
  logic [1:0]  req = '0;
  logic        int_w;
  logic        inta = 1'b0;
  logic [1:0]  iack;
  logic [7:0]  vec;
  logic        vec_oe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  intarb_top i_intarb_top (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_we_i    (we),
    .bus_rdata_o (rdata),
    .irq_req_i   (req),
    .int_o       (int_w),
    .inta_i      (inta),
    .iack_o      (iack),
    .vec_o       (vec),
    .vec_oe_o    (vec_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1 chk(tag, 32'(rdata), 32'(exp));
  endtask

  task automatic ack_start();
    @(negedge clk);
    inta = 1'b1;
    @(negedge clk);
    #1;
  endtask

  task automatic ack_end();
    @(negedge clk);
    inta = 1'b0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1 int", 32'(int_w), 0);
    chk("R1 iack", 32'(iack), 0);
    chk("R1 oe", 32'(vec_oe), 0);
    rd_chk("R1 mask", A_MASK, 8'h00);
    rd_chk("R1 ix0", A_IX0, 8'h00);
    rd_chk("R1 ix1", A_IX1, 8'h00);
    rd_chk("R1 ena", A_ENA, 8'h00);

    // R2 register map and field widths
    wr(A_MASK, 8'hFF);
    rd_chk("R2 mask", A_MASK, 8'h03);
    wr(A_ENA, 8'hFE);
    rd_chk("R2 ena bit0 only", A_ENA, 8'h00);
    wr(A_ENA, 8'hFF);
    rd_chk("R2 ena", A_ENA, 8'h01);
    wr(A_IX0, IX0);
    wr(A_IX1, IX1);
    rd_chk("R2 ix0", A_IX0, IX0);
    rd_chk("R2 ix1", A_IX1, IX1);

    // R10 writes outside the window
    wr(16'hFFF4, 8'hAA);
    wr(16'hFFEF, 8'h55);
    wr(16'h0000, 8'h00);
    rd_chk("R10 mask", A_MASK, 8'h03);
    rd_chk("R10 ix0", A_IX0, IX0);
    rd_chk("R10 ix1", A_IX1, IX1);
    rd_chk("R10 ena", A_ENA, 8'h01);
    rd_chk("R10 unmapped read", 16'hFFF4, 8'h00);

    // table walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 8; i++) begin
      wr(A_MASK, {6'd0, VECS[i][15:14]});
      wr(A_ENA, {7'd0, VECS[i][13]});
      @(negedge clk);
      req = VECS[i][12:11];
      #1 chk($sformatf("R3 R4 R5 int v%0d", i), 32'(int_w), 32'(VECS[i][10]));
      ack_start();
      chk($sformatf("R6 R7 R5 iack v%0d", i), 32'(iack), 32'(VECS[i][9:8]));
      chk($sformatf("R7 vec v%0d", i), 32'(vec), 32'(VECS[i][7:0]));
      chk($sformatf("R7 oe v%0d", i), 32'(vec_oe), 32'(VECS[i][9:8] != 2'b00));
      ack_end();
      chk($sformatf("R8 iack v%0d", i), 32'(iack), 0);
      chk($sformatf("R8 oe v%0d", i), 32'(vec_oe), 0);
      chk($sformatf("R8 vec v%0d", i), 32'(vec), 0);
      @(negedge clk);
      req = 2'b00;
    end

    // R7 latched winner holds when a higher-priority request arrives late
    wr(A_MASK, 8'h03);
    wr(A_ENA, 8'h01);
    @(negedge clk);
    req = 2'b10;
    ack_start();
    chk("R7 latch ch1", 32'(iack), 32'h2);
    @(negedge clk);
    req = 2'b11;
    @(negedge clk);
    @(negedge clk);
    #1;
    chk("R7 hold iack", 32'(iack), 32'h2);
    chk("R7 hold vec", 32'(vec), 32'(IX1));
    ack_end();

    // R9 int stays up while the other channel still waits
    @(negedge clk);
    req = 2'b11;
    ack_start();
    chk("R9 first ch0", 32'(iack), 32'h1);
    @(negedge clk);
    req = 2'b10;
    ack_end();
    chk("R9 int held", 32'(int_w), 1);
    @(negedge clk);
    ack_start();
    chk("R9 second ch1", 32'(iack), 32'h2);
    chk("R9 second vec", 32'(vec), 32'(IX1));
    ack_end();
    @(negedge clk);
    req = 2'b00;
    #1 chk("R9 int drop", 32'(int_w), 0);

    // R4 disabling mid-request drops int immediately after the write
    @(negedge clk);
    req = 2'b01;
    wr(A_ENA, 8'h00);
    #1 chk("R4 disabled int", 32'(int_w), 0);
    ack_start();
    chk("R4 disabled ack", 32'(iack), 0);
    chk("R4 disabled oe", 32'(vec_oe), 0);
    ack_end();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule